// File: doc/BRIEF.md
# Keyed Two-Pass Hash Sequencer

This block computes a keyed message authentication code by running a block-oriented hash compression engine over two nested passes. It takes a secret key and then a message as streams of 32-bit words. From the key it forms a 512-bit working key. It then runs an inner pass over the working key XORed with the inner pad, followed by the message. An outer pass follows over the working key XORed with the outer pad, followed by the 160-bit inner digest. The outer digest is cut down to a chosen number of leading bytes.

The compression engine is outside the block. It is reached through a request/acknowledge port. The sequencer presents a 512-bit block and a 160-bit chaining value, holds them until the engine acknowledges, and takes back the new chaining value. The sequencer does all of the message padding itself. A key longer than one block is first hashed on its own through the same engine, and the 160-bit digest of that pass becomes the working key.

Message and key lengths are whole 32-bit words. Words are big-endian within a block: word 0 sits in bits 511:480.

Top module: `hmac_seq`

## Requirements
- R1: With the hash H defined as chaining from the initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0 through the engine, and padded by appending word 0x80000000, then zero words until the word count is 14 mod 16, then the 64-bit total bit count as two words, high word first, the full result is H((K0 XOR opad) || H((K0 XOR ipad) || msg)). Here ipad is byte 0x36 repeated 64 times and opad is byte 0x5C repeated 64 times.
- R2: A key of 1 to 16 words is used as K0 directly: the key words are left-aligned in a 512-bit value and the remainder is filled with zeros.
- R3: A key of 17 or more words is first hashed with H and no prefix. K0 is then the 160-bit digest in bits 511:352, with zeros below.
- R4: After an accepted start, key words and then message words are taken on `in_data` whenever `in_valid` and `in_ready` are both high. Each group ends with a word that has `in_last` set, and each group has at least one word. `in_ready` is only high while `busy` is high.
- R5: `eng_req` stays high, with `eng_blk` and `eng_hin` stable, until a cycle with `eng_ack` high. The number of engine acknowledges per operation equals the number of compressions that R1 to R3 imply.
- R6: `mac_out` holds the first t bytes of the outer digest, counted from bit 159, and zero in all lower bytes. t is `mac_bytes` sampled at start, with 0 treated as 1 and values above 20 treated as 20.
- R7: `done` rises together with a valid `mac_out`. Both then hold until the next accepted start. `done` and `busy` are never high together.
- R8: A start pulse while `busy` is high is ignored, including its `mac_bytes`.
- R9: A final block with no room for the marker word and both length words causes one extra compression. A message of 14 words takes two inner message blocks, while 13 words take one.
- R10: After reset, `busy`, `done`, `in_ready` and `eng_req` are low and `mac_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (only acted on while idle) |
| mac_bytes | input | 5 | Number of output bytes kept, sampled at start |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Sequencer accepts an input word |
| in_data | input | 32 | Key or message word |
| in_last | input | 1 | Marks the last word of the key group or message group |
| eng_req | output | 1 | Compression request to the engine |
| eng_blk | output | 512 | Block presented to the engine |
| eng_hin | output | 160 | Chaining value presented to the engine |
| eng_ack | input | 1 | Engine result valid, ends the request |
| eng_hout | input | 160 | New chaining value from the engine |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid |
| mac_out | output | 160 | Truncated code, zero beyond t bytes |

## Verification
The cases vary the key length across the direct-use range and the hashed range: 1, 5, 16, 17 and 20 words. They also vary the message length so that the padded tail either fits in the last block or spills into an extra one: 1, 3, 13, 14 and 16 words. Comparing the code against an independent model separates a wrong key normalisation, a wrong pad constant or a wrong concatenation order. Comparing the count of engine calls separates a missing or extra padding block. The truncation lengths 0, 1, 12, 20 and 25 cover the clamping and the zeroed tail. A second start issued during a run must leave both the result and the length unchanged.

// File: rtl/hmac_seq_pkg.sv
// Package: shared sizes, constants and state encodings for the sequencer.
// Assumes a 512-bit block, a 160-bit digest and 32-bit input words.
package hmac_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int DIG_WORDS = 5;
    localparam int DIG_W     = WORD_W * DIG_WORDS;
    localparam int DIG_BYTES = DIG_W / 8;
    localparam int LEN_W     = 2 * WORD_W;
    localparam int CNT_W     = $clog2(BLK_WORDS + 1);
    localparam int IDX_W     = $clog2(BLK_WORDS);
    localparam int TB_W      = $clog2(DIG_BYTES + 1);

    localparam logic [DIG_W-1:0] HASH_IV =
        {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
    localparam logic [7:0]        IPAD_BYTE = 8'h36;
    localparam logic [7:0]        OPAD_BYTE = 8'h5C;
    localparam logic [WORD_W-1:0] MARK_WORD = 32'h8000_0000;

    typedef enum logic [3:0] {
        ST_IDLE, ST_KEY, ST_KEND, ST_IPAD, ST_MSG,
        ST_PAD, ST_PAD2, ST_CMP, ST_FIN, ST_OUTER
    } seq_st_t;

    typedef enum logic [1:0] {STR_KEY, STR_INNER, STR_OUTER} stream_t;
endpackage

// File: rtl/hmac_blk_buf.sv
// Block buffer: holds one 512-bit compression block.
// Supports a whole-block load, a clear, a single-word write and a write of the
// length field into the two lowest words. Word 0 occupies the top bits.
// Assumes the controller never loads and writes a word in the same cycle.
module hmac_blk_buf
    import hmac_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              len_en,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              ld_en,
    input  logic [BLK_W-1:0]  ld_data,
    output logic [BLK_W-1:0]  blk
);
    // Update the block: load has priority, then clear, then word and length writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk <= '0;
        end else if (ld_en) begin
            blk <= ld_data;
        end else if (clr) begin
            blk <= '0;
        end else begin
            if (wr_en)  blk[BLK_W-1-WORD_W*wr_idx -: WORD_W] <= wr_data;
            if (len_en) blk[LEN_W-1:0] <= len_val;
        end
    end

    // R1: each block is built from one source at a time
    a_r1_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && (wr_en || len_en)));
endmodule

// File: rtl/hmac_trunc.sv
// Truncation: keeps the leading nbytes bytes of the digest and zeroes the rest.
// Assumes nbytes is already clamped to the range 1..20.
module hmac_trunc
    import hmac_seq_pkg::*;
(
    input  logic [DIG_W-1:0] full,
    input  logic [TB_W-1:0]  nbytes,
    output logic [DIG_W-1:0] mac
);
    // One mask stage per output byte.
    for (genvar b = 0; b < DIG_BYTES; b++) begin : g_byte
        assign mac[DIG_W-1-8*b -: 8] =
            (nbytes > TB_W'(b)) ? full[DIG_W-1-8*b -: 8] : 8'h00;
    end
endmodule

// File: rtl/hmac_seq.sv
// Keyed two-pass hash sequencer: normalises the key, then drives an external
// compression engine through the inner pass and the outer pass, doing the
// padding itself, and truncates the outer digest.
// A full block is compressed only when more data arrives or the stream ends.
// Assumes the engine holds eng_ack high for a single cycle per request.
module hmac_seq
    import hmac_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TB_W-1:0]   mac_bytes,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              eng_req,
    output logic [BLK_W-1:0]  eng_blk,
    output logic [DIG_W-1:0]  eng_hin,
    input  logic              eng_ack,
    input  logic [DIG_W-1:0]  eng_hout,
    output logic              busy,
    output logic              done,
    output logic [DIG_W-1:0]  mac_out
);
    localparam logic [BLK_W-1:0] IPAD_BLK = {(BLK_W/8){IPAD_BYTE}};
    localparam logic [BLK_W-1:0] OPAD_BLK = {(BLK_W/8){OPAD_BYTE}};
    localparam int               TAIL_W   = BLK_W - DIG_W;

    seq_st_t           state, ret_st;
    stream_t           stream;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  bitlen;
    logic [DIG_W-1:0]  chain, inner_dg, mac_q;
    logic [BLK_W-1:0]  k0, blk;
    logic [TB_W-1:0]   tlen;
    logic              keyhashed, done_q;

    logic              b_clr, b_wr, b_len, b_ld;
    logic [WORD_W-1:0] b_wdata;
    logic [BLK_W-1:0]  b_ld_data;
    logic              blk_full;

    assign blk_full = (cnt == CNT_W'(BLK_WORDS));
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign in_ready = ((state == ST_KEY) || (state == ST_MSG)) && !blk_full;
    assign eng_req  = (state == ST_CMP);
    assign eng_blk  = blk;
    assign eng_hin  = chain;

    // Choose this cycle's buffer operation from the state.
    always_comb begin
        b_clr = 1'b0; b_wr = 1'b0; b_len = 1'b0; b_ld = 1'b0;
        b_wdata = in_data; b_ld_data = '0;
        case (state)
            ST_IDLE:        b_clr = start;
            ST_KEY, ST_MSG: b_wr  = in_valid && !blk_full;
            ST_IPAD: begin b_ld = 1'b1; b_ld_data = k0 ^ IPAD_BLK; end
            ST_PAD:  begin b_wr = !blk_full; b_wdata = MARK_WORD; end
            ST_PAD2:        b_len = (cnt <= CNT_W'(BLK_WORDS - 2));
            ST_CMP:         b_clr = eng_ack;
            ST_FIN: if (stream == STR_INNER) begin
                b_ld = 1'b1; b_ld_data = k0 ^ OPAD_BLK;
            end
            ST_OUTER: begin b_ld = 1'b1; b_ld_data = {inner_dg, {TAIL_W{1'b0}}}; end
            default: ;
        endcase
    end

    hmac_blk_buf u_buf (
        .clk(clk), .rst_n(rst_n), .clr(b_clr),
        .wr_en(b_wr), .wr_idx(cnt[IDX_W-1:0]), .wr_data(b_wdata),
        .len_en(b_len), .len_val(bitlen),
        .ld_en(b_ld), .ld_data(b_ld_data), .blk(blk)
    );

    hmac_trunc u_trunc (.full(mac_q), .nbytes(tlen), .mac(mac_out));

    // Sequence the passes: key intake, inner pass, outer pass, padding, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; ret_st <= ST_IDLE; stream <= STR_KEY;
            cnt <= '0; bitlen <= '0; chain <= '0; inner_dg <= '0;
            mac_q <= '0; k0 <= '0; tlen <= TB_W'(1); keyhashed <= 1'b0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_KEY; stream <= STR_KEY; cnt <= '0;
                    bitlen <= '0; chain <= HASH_IV; keyhashed <= 1'b0;
                    done_q <= 1'b0;
                    tlen <= (mac_bytes == '0) ? TB_W'(1) :
                            (mac_bytes > TB_W'(DIG_BYTES)) ? TB_W'(DIG_BYTES) : mac_bytes;
                end
                ST_KEY, ST_MSG: if (in_valid) begin
                    if (blk_full) begin
                        ret_st <= state; state <= ST_CMP;
                        if (state == ST_KEY) keyhashed <= 1'b1;
                    end else begin
                        cnt    <= cnt + 1'b1;
                        bitlen <= bitlen + LEN_W'(WORD_W);
                        if (in_last) state <= (state == ST_KEY) ? ST_KEND : ST_PAD;
                    end
                end
                ST_KEND: if (keyhashed) state <= ST_PAD;
                         else begin k0 <= blk; state <= ST_IPAD; end
                ST_IPAD: begin
                    chain <= HASH_IV; bitlen <= LEN_W'(BLK_W);
                    stream <= STR_INNER; ret_st <= ST_MSG; state <= ST_CMP;
                end
                ST_PAD: if (blk_full) begin ret_st <= ST_PAD; state <= ST_CMP; end
                        else begin cnt <= cnt + 1'b1; state <= ST_PAD2; end
                ST_PAD2: begin
                    ret_st <= (cnt > CNT_W'(BLK_WORDS - 2)) ? ST_PAD2 : ST_FIN;
                    state  <= ST_CMP;
                end
                ST_CMP: if (eng_ack) begin
                    chain <= eng_hout; cnt <= '0; state <= ret_st;
                end
                ST_FIN: case (stream)
                    STR_KEY:   begin k0 <= {chain, {TAIL_W{1'b0}}}; state <= ST_IPAD; end
                    STR_INNER: begin
                        inner_dg <= chain; chain <= HASH_IV;
                        ret_st <= ST_OUTER; state <= ST_CMP;
                    end
                    default:   begin mac_q <= chain; done_q <= 1'b1; state <= ST_IDLE; end
                endcase
                ST_OUTER: begin
                    cnt <= CNT_W'(DIG_WORDS); bitlen <= LEN_W'(BLK_W + DIG_W);
                    stream <= STR_OUTER; state <= ST_PAD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a pending request keeps its block and chaining value
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack |=> eng_req && $stable(eng_blk) && $stable(eng_hin));
    // R4: words are only offered acceptance during an operation
    a_r4_ready_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
    // R7: result flag and activity never overlap
    a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    // R7: the code holds while the result stays valid
    a_r7_mac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(done) |-> $stable(mac_out));
    // R8: the truncation length cannot change mid-operation
    a_r8_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(tlen));
    // R9: the fill count never passes one block
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BLK_WORDS));
endmodule

// File: tb/hmac_seq_bench.sv
module hmac_seq_bench;
    import hmac_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TB_W-1:0]   mac_bytes = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              eng_req;
    logic [BLK_W-1:0]  eng_blk;
    logic [DIG_W-1:0]  eng_hin;
    logic              eng_ack = 1'b0;
    logic [DIG_W-1:0]  eng_hout = '0;
    logic              busy, done;
    logic [DIG_W-1:0]  mac_out;

    int n_chk = 0, n_fail = 0, eng_calls = 0, mdl_calls = 0;
    int eng_lat = 0, eng_wait = 0;
    bit finished = 1'b0;

    logic [WORD_W-1:0] key [0:31];
    logic [WORD_W-1:0] msg [0:31];
    logic [WORD_W-1:0] src [0:31];
    logic [WORD_W-1:0] pw  [0:63];

    always #2.5 clk = ~clk;

    hmac_seq u_hmac_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mac_bytes(mac_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .eng_req(eng_req), .eng_blk(eng_blk),
        .eng_hin(eng_hin), .eng_ack(eng_ack), .eng_hout(eng_hout),
        .busy(busy), .done(done), .mac_out(mac_out)
    );

    // Stand-in compression function, also used by the reference model.
    function automatic logic [DIG_W-1:0] tf(input logic [DIG_W-1:0] h, input logic [BLK_W-1:0] b);
        logic [31:0] a0, a1, a2, a3, a4, t;
        {a0, a1, a2, a3, a4} = h;
        for (int i = 0; i < 16; i++) begin
            t  = {a0[26:0], a0[31:27]} + a4 + b[BLK_W-1-32*i -: 32] + 32'h5A827999 + (a1 ^ a2 ^ a3);
            a4 = a3; a3 = a2; a2 = {a1[1:0], a1[31:2]}; a1 = a0; a0 = t;
        end
        return {h[159:128] + a0, h[127:96] + a1, h[95:64] + a2, h[63:32] + a3, h[31:0] + a4};
    endfunction

    // Engine model: acknowledges a request after eng_lat idle cycles.
    always @(negedge clk) begin
        eng_ack = 1'b0;
        if (eng_req) begin
            if (eng_wait >= eng_lat) begin
                eng_hout  = tf(eng_hin, eng_blk);
                eng_ack   = 1'b1;
                eng_wait  = 0;
                eng_calls = eng_calls + 1;
            end else eng_wait = eng_wait + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DIG_W-1:0] act, input logic [DIG_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference hash over src[0..n-1] with padding, starting from chain h0.
    task automatic mdl_hash(input logic [DIG_W-1:0] h0, input int n,
                            input logic [63:0] prebits, output logic [DIG_W-1:0] hout);
        logic [DIG_W-1:0] h;
        logic [63:0] bits;
        logic [BLK_W-1:0] b;
        int m;
        h = h0;
        for (int i = 0; i < n; i++) pw[i] = src[i];
        pw[n] = 32'h8000_0000;
        m = n + 1;
        while (m % 16 != 14) begin pw[m] = '0; m++; end
        bits = prebits + 64'(n) * 64'd32;
        pw[m] = bits[63:32]; pw[m+1] = bits[31:0]; m += 2;
        for (int bi = 0; bi < m / 16; bi++) begin
            for (int w = 0; w < 16; w++) b[BLK_W-1-32*w -: 32] = pw[bi*16+w];
            h = tf(h, b);
            mdl_calls++;
        end
        hout = h;
    endtask

    // Reference keyed code for key[0..klen-1], msg[0..mlen-1], length t.
    task automatic mdl_mac(input int klen, input int mlen, input int t,
                           output logic [DIG_W-1:0] mac);
        logic [BLK_W-1:0] k0;
        logic [DIG_W-1:0] h, ih, oh, kd;
        int tc;
        mdl_calls = 0;
        k0 = '0;
        if (klen > 16) begin
            for (int i = 0; i < klen; i++) src[i] = key[i];
            mdl_hash(HASH_IV, klen, 64'd0, kd);
            k0[BLK_W-1 -: DIG_W] = kd;
        end else begin
            for (int i = 0; i < klen; i++) k0[BLK_W-1-32*i -: 32] = key[i];
        end
        h = tf(HASH_IV, k0 ^ {64{8'h36}}); mdl_calls++;
        for (int i = 0; i < mlen; i++) src[i] = msg[i];
        mdl_hash(h, mlen, 64'd512, ih);
        h = tf(HASH_IV, k0 ^ {64{8'h5C}}); mdl_calls++;
        for (int i = 0; i < 5; i++) src[i] = ih[DIG_W-1-32*i -: 32];
        mdl_hash(h, 5, 64'd512, oh);
        tc = (t == 0) ? 1 : (t > 20) ? 20 : t;
        mac = '0;
        for (int b = 0; b < tc; b++) mac[DIG_W-1-8*b -: 8] = oh[DIG_W-1-8*b -: 8];
    endtask

    // Offer one word at a negedge and hold it until the following edge takes it.
    task automatic send_word(input logic [WORD_W-1:0] d, input bit last);
        in_valid = 1'b1; in_data = d; in_last = last;
        forever begin
            if (in_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // One full operation, checked against the model.
    task automatic run_case(input string tag, input int klen, input int mlen, input int t,
                            input int lat, input int seed, input bit poke);
        logic [DIG_W-1:0] exp, held;
        for (int i = 0; i < klen; i++) key[i] = 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h01000193;
        for (int i = 0; i < mlen; i++) msg[i] = 32'(seed) * 32'h7F4A7C15 ^ (32'(i) << 8) ^ 32'h00C0FFEE;
        mdl_mac(klen, mlen, t, exp);
        eng_lat = lat; eng_calls = 0;
        @(negedge clk);
        start = 1'b1; mac_bytes = TB_W'(t);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < klen; i++) begin
            send_word(key[i], i == klen - 1);
            if (poke && i == 0) begin
                start = 1'b1; mac_bytes = TB_W'(7);
                @(negedge clk);
                start = 1'b0; mac_bytes = TB_W'(t);
                chk(busy == 1'b1, "R8", {tag, " busy after second start"}, DIG_W'(busy), DIG_W'(1));
            end
        end
        for (int i = 0; i < mlen; i++) send_word(msg[i], i == mlen - 1);
        while (!done) @(negedge clk);
        chk(mac_out == exp, "R1", {tag, " code"}, mac_out, exp);
        chk(eng_calls == mdl_calls, "R5", {tag, " engine calls"}, DIG_W'(eng_calls), DIG_W'(mdl_calls));
        chk(!busy, "R7", {tag, " busy with done"}, DIG_W'(busy), DIG_W'(0));
        held = mac_out;
        repeat (5) @(negedge clk);
        chk(done && mac_out == held, "R7", {tag, " result held"}, mac_out, held);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !in_ready && !eng_req, "R10", "reset flags",
            DIG_W'({busy, done, in_ready, eng_req}), DIG_W'(0));
        chk(mac_out == '0, "R10", "reset code", mac_out, '0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_case("R2 short key", 5, 3, 20, 0, 1, 1'b0);
        run_case("R2 R9 R6 full-block key and message", 16, 16, 12, 2, 2, 1'b0);
        run_case("R3 R9 hashed key, spilling tail", 20, 14, 1, 1, 3, 1'b0);
        run_case("R3 R6 one-word-over key, fitting tail", 17, 13, 0, 3, 4, 1'b0);
        run_case("R8 R6 second start ignored", 1, 1, 25, 0, 5, 1'b1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule